// File: doc/BRIEF.md
# Stepper Phase Sequencer with Move Counter

The block drives the four coil lines of a unipolar stepper motor from one packed 32-bit phase word. The word is split into eight 4-bit nibbles. Each nibble is put on the coils for one programmed step period, and the whole word then repeats. Full-step, half-step, forward, reverse and a hold-still pattern are all just different words. One example is 0x12481248, which turns the motor forward one coil at a time.

A move counter watches coil line 3 and counts its rising edges. Once the count for the current move reaches the programmed step count, it raises a stop request. A command is a triple of step period, pattern word and step count. It waits in a one-deep slot. At the end of a full pattern, if the stop request is high and a command is waiting, the sequencer switches to that command in the very next cycle. A separate 32-bit total counts every rising edge on coil line 3 since reset.

Top module: `stepSequencer`

## Requirements
- R1: After reset the coils play the stop word 0x80808080 with a step period of 4 clocks. `ready` is high, `stopReq` is high (step target 0) and `stepTotal` is 0.
- R2: Nibbles are applied least significant first, so nibble k drives coil bits [3:0] from pattern bits [4k+3:4k]. Each nibble is held for exactly `cmdPeriod` clocks.
- R3: A step period of 0 behaves as a period of 1 clock.
- R4: While the stop word runs, coil lines 0 to 2 stay low and only coil line 3 toggles.
- R5: `stopReq` is high whenever the number of rising edges on coil line 3 since the active command was loaded is at least that command's step count. A step count of 0 gives `stopReq` at once.
- R6: `ready` is high exactly when the command slot is empty. With `ready` high, `cmdValid` stores the triple and `ready` falls in the next cycle. While `ready` is low, `cmdValid` is ignored.
- R7: A stored command takes effect only after the last clock of nibble 7, and only if `stopReq` is high. Its nibble 0 appears in the next cycle, with no idle gap.
- R8: If no command is stored at the end of a pattern, the current pattern repeats unchanged. `stopReq` then stays high until a command is loaded.
- R9: `stepTotal` rises by one for each rising edge on coil line 3. It is never cleared by a load and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Offers a command triple |
| cmdPeriod | input | 32 | Clocks per step (0 treated as 1) |
| cmdPattern | input | 32 | Eight packed 4-bit coil nibbles |
| cmdSteps | input | 32 | Coil-3 rising edges before stop is requested |
| coil | output | 4 | Coil drive lines |
| ready | output | 1 | Command slot empty |
| stopReq | output | 1 | Move count reached |
| stepTotal | output | 32 | Cumulative coil-3 rising edges |

## Verification
The bench plays five words in turn:
- The stop word, which shows that only coil line 3 moves.
- Forward full-step with a 3-clock period, which fixes the nibble order and the hold length.
- Half-step with period 0, which has one coil-3 edge per pattern instead of two and exercises the zero-period rule.
- Reverse full-step queued while another move runs, which must switch with no gap.
- A zero-step command, which must give an immediate stop request.

A second offer made while the slot is full uses a different word. It would visibly change the coil sequence if it were wrongly accepted.

// File: rtl/stepPkg.sv
package stepPkg;
  typedef struct packed {
    logic stepAdvance;  // last clock of the current nibble
    logic loadCmd;      // switch to the stored command
    logic acceptCmd;    // capture an offered command into the slot
  } ctrlStrobes_t;
endpackage

// File: rtl/stepCtrl.sv
module stepCtrl #(
  parameter int NIBBLES = 8,
  localparam int IDX_W = $clog2(NIBBLES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  input  logic periodDone,
  input  logic stopReq,
  output stepPkg::ctrlStrobes_t strb,
  output logic [IDX_W-1:0] nibIdx,
  output logic ready
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBBLES - 1);

  logic pending;
  logic patWrap;

  always_comb begin
    patWrap          = periodDone && (nibIdx == LAST_IDX);
    strb.stepAdvance = periodDone;
    strb.loadCmd     = patWrap && stopReq && pending;
    strb.acceptCmd   = cmdValid && !pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      nibIdx  <= '0;
    end else begin
      if (strb.loadCmd)        pending <= 1'b0;
      else if (strb.acceptCmd) pending <= 1'b1;
      if (periodDone) nibIdx <= patWrap ? '0 : nibIdx + 1'b1;
    end
  end

  assign ready = !pending;
endmodule

// File: rtl/stepDatapath.sv
module stepDatapath #(
  parameter int COILS = 4,
  parameter int PAT_W = 32,
  parameter int CNT_W = 32,
  parameter int RST_PERIOD = 4,
  parameter logic [PAT_W-1:0] STOP_PAT = 32'h8080_8080,
  localparam int NIBBLES = PAT_W / COILS,
  localparam int IDX_W = $clog2(NIBBLES)
) (
  input  logic clk,
  input  logic rstN,
  input  stepPkg::ctrlStrobes_t strb,
  input  logic [IDX_W-1:0] nibIdx,
  input  logic [CNT_W-1:0] cmdPeriod,
  input  logic [PAT_W-1:0] cmdPattern,
  input  logic [CNT_W-1:0] cmdSteps,
  output logic periodDone,
  output logic stopReq,
  output logic [COILS-1:0] coil,
  output logic [CNT_W-1:0] stepTotal
);
  logic [CNT_W-1:0] pendPeriod, pendSteps, actPeriod, target;
  logic [PAT_W-1:0] pendPattern, actPattern;
  logic [CNT_W-1:0] periodCnt, periodLimit, moveCnt;
  logic prevSense, senseRise;
  logic [COILS-1:0] nibs [NIBBLES];

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign nibs[g] = actPattern[g*COILS +: COILS];
  end

  assign coil        = nibs[nibIdx];
  assign periodLimit = (actPeriod == '0) ? '0 : actPeriod - 1'b1;
  assign periodDone  = (periodCnt == periodLimit);
  assign senseRise   = coil[COILS-1] & ~prevSense;
  assign stopReq     = (moveCnt >= target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPeriod  <= '0;
      pendPattern <= '0;
      pendSteps   <= '0;
    end else if (strb.acceptCmd) begin
      pendPeriod  <= cmdPeriod;
      pendPattern <= cmdPattern;
      pendSteps   <= cmdSteps;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPeriod  <= CNT_W'(RST_PERIOD);
      actPattern <= STOP_PAT;
      target     <= '0;
      moveCnt    <= '0;
    end else if (strb.loadCmd) begin
      actPeriod  <= pendPeriod;
      actPattern <= pendPattern;
      target     <= pendSteps;
      moveCnt    <= '0;
    end else begin
      moveCnt    <= moveCnt + CNT_W'(senseRise);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      prevSense <= 1'b0;
      stepTotal <= '0;
    end else begin
      periodCnt <= strb.stepAdvance ? '0 : periodCnt + 1'b1;
      prevSense <= coil[COILS-1];
      stepTotal <= stepTotal + CNT_W'(senseRise);
    end
  end
endmodule

// File: rtl/stepSequencer.sv
module stepSequencer #(
  parameter int COILS = 4,
  parameter int PAT_W = 32,
  parameter int CNT_W = 32,
  parameter int RST_PERIOD = 4,
  parameter logic [PAT_W-1:0] STOP_PAT = 32'h8080_8080
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  input  logic [CNT_W-1:0] cmdPeriod,
  input  logic [PAT_W-1:0] cmdPattern,
  input  logic [CNT_W-1:0] cmdSteps,
  output logic [COILS-1:0] coil,
  output logic ready,
  output logic stopReq,
  output logic [CNT_W-1:0] stepTotal
);
  localparam int NIBBLES = PAT_W / COILS;
  localparam int IDX_W = $clog2(NIBBLES);

  stepPkg::ctrlStrobes_t strb;
  logic [IDX_W-1:0] nibIdx;
  logic periodDone;

  stepCtrl #(.NIBBLES(NIBBLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .periodDone(periodDone),
    .stopReq(stopReq), .strb(strb), .nibIdx(nibIdx), .ready(ready)
  );

  stepDatapath #(
    .COILS(COILS), .PAT_W(PAT_W), .CNT_W(CNT_W),
    .RST_PERIOD(RST_PERIOD), .STOP_PAT(STOP_PAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nibIdx(nibIdx),
    .cmdPeriod(cmdPeriod), .cmdPattern(cmdPattern), .cmdSteps(cmdSteps),
    .periodDone(periodDone), .stopReq(stopReq), .coil(coil), .stepTotal(stepTotal)
  );
endmodule

// File: rtl/stepSequencerChecks.sv
module stepSequencerChecks #(
  parameter int COILS = 4,
  parameter int CNT_W = 32
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic ready,
  input logic stopReq,
  input logic periodDone,
  input logic loadCmd,
  input logic [COILS-1:0] coil,
  input logic [CNT_W-1:0] stepTotal
);
  // R2: coils move only after the last clock of a nibble
  p_coil_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !periodDone |=> $stable(coil));

  // R6: an empty slot stays empty without an offer
  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !cmdValid) |=> ready);

  // R6: an offer into an empty slot fills it
  p_ready_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && cmdValid) |=> !ready);

  // R7: a load empties the slot
  p_load_frees_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadCmd |=> ready);

  // R8: a stop request persists until a load
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !loadCmd) |=> stopReq);

  // R9: the total advances by at most one per clock
  p_total_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (stepTotal == $past(stepTotal)) || (stepTotal == $past(stepTotal) + 1'b1));
endmodule

bind stepSequencer stepSequencerChecks #(.COILS(COILS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .ready(ready), .stopReq(stopReq),
  .periodDone(periodDone), .loadCmd(strb.loadCmd), .coil(coil), .stepTotal(stepTotal)
);

// File: tb/sim_stepSequencer.sv
module sim_stepSequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [31:0] cmdPeriod = '0, cmdPattern = '0, cmdSteps = '0;
  logic [3:0] coil;
  logic ready, stopReq;
  logic [31:0] stepTotal;

  int total = 0, bad = 0, cycles = 0;
  string coilTag = "R4";
  string stopTag = "R8";
  logic done = 1'b0;

  always #10 clk = ~clk;

  stepSequencer u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPeriod(cmdPeriod),
    .cmdPattern(cmdPattern), .cmdSteps(cmdSteps), .coil(coil), .ready(ready),
    .stopReq(stopReq), .stepTotal(stepTotal)
  );

  // behavioural reference
  logic [31:0] mPat, mPer, mCnt, mTarget, mMove, mTotal, pPer, pPat, pSteps;
  int mIdx;
  logic mPend, mPrev3;

  always @(posedge clk) begin
    if (!rstN) begin
      mPat = 32'h8080_8080; mPer = 4; mCnt = 0; mIdx = 0; mPend = 0;
      mTarget = 0; mMove = 0; mTotal = 0; mPrev3 = 0;
      pPer = 0; pPat = 0; pSteps = 0;
    end else begin
      logic [3:0] cur;
      logic rise, stopNow, doLoad, doAccept;
      logic [31:0] eff;
      cur = 4'((mPat >> (4 * mIdx)) & 32'hF);
      rise = cur[3] && !mPrev3;
      mPrev3 = cur[3];
      stopNow = (mMove >= mTarget);
      eff = (mPer == 0) ? 1 : mPer;
      doLoad = 0;
      doAccept = cmdValid && !mPend;
      if (mCnt == eff - 1) begin
        mCnt = 0;
        if (mIdx == 7) begin
          mIdx = 0;
          if (stopNow && mPend) doLoad = 1;
        end else mIdx = mIdx + 1;
      end else mCnt = mCnt + 1;
      mTotal = mTotal + {31'b0, rise};
      if (doLoad) begin
        mPat = pPat; mPer = pPer; mTarget = pSteps; mMove = 0; mPend = 0;
      end else mMove = mMove + {31'b0, rise};
      if (doAccept) begin
        mPend = 1; pPer = cmdPeriod; pPat = cmdPattern; pSteps = cmdSteps;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check(coilTag, {28'b0, coil}, (mPat >> (4 * mIdx)) & 32'hF);
      check("R6", {31'b0, ready}, {31'b0, !mPend});
      check(stopTag, {31'b0, stopReq}, {31'b0, (mMove >= mTarget)});
      check("R9", stepTotal, mTotal);
      if (mPat == 32'h8080_8080) check("R4", {29'b0, coil[2:0]}, 0);
    end
  end

  task automatic sendCmd(input logic [31:0] per, input logic [31:0] pat, input logic [31:0] st);
    while (!ready) @(negedge clk);
    cmdValid = 1; cmdPeriod = per; cmdPattern = pat; cmdSteps = st;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state
    check("R1", {28'b0, coil}, 0);
    check("R1", {31'b0, ready}, 1);
    check("R1", {31'b0, stopReq}, 1);
    check("R1", stepTotal, 0);
    idle(70);                               // stop word repeats (R4, R8)
    coilTag = "R2";
    stopTag = "R5";
    sendCmd(3, 32'h1248_1248, 4);
    // R6: offers while the slot is full are ignored
    cmdValid = 1; cmdPeriod = 7; cmdPattern = 32'h8421_8421; cmdSteps = 1;
    idle(3);
    cmdValid = 0;
    idle(180);
    stopTag = "R8";
    idle(40);                               // forward repeats with no command stored
    coilTag = "R3";
    stopTag = "R5";
    sendCmd(0, 32'h1326_4c89, 2);
    idle(40);
    coilTag = "R7";
    sendCmd(2, 32'h8421_8421, 3);           // queued during a move: no gap
    idle(120);
    sendCmd(1, 32'h98c4_6231, 5);
    idle(120);
    stopTag = "R5";
    sendCmd(1, 32'h8080_8080, 0);           // zero steps: stop at once
    idle(80);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule